// File: doc/BRIEF.md
# Soft-Start Fault Sequencer With Hiccup Retry

This block sequences start-up and overcurrent recovery for a phase-shifted bridge controller. It watches three single-bit conditions: a supply-good flag (hysteresis already applied upstream), a reference-good flag and an overcurrent comparator flag. It keeps a digital soft-start level, produces the enable for the gate drivers and produces a limit for the phase command that passes downstream.

An overcurrent sets a fault latch, turns the drivers off in the same cycle and drops the soft-start level to zero. While the latch is set the level still rises. The latch can be released only when the level reaches full scale. If the overcurrent is still present at that point, the level drops to zero again and another full charge begins. A fault that persists therefore gives a slow hiccup retry. Once the latch is released, the level restarts from zero. The drivers come on at zero phase when the level reaches a low threshold, and the phase limit then grows with the level.

Top module: `hiccup_seq`

## Requirements
- R1: While supply_ok_i is low, drv_en_o and phase_lim_o are zero. On the next clock edge the fault latch is cleared and ss_level_o becomes zero, so a fault that was latched before the supply loss does not delay the next start-up.
- R2: While ref_ok_i is low, the block behaves as in R1, even when supply_ok_i is high.
- R3: With both readiness flags high, ss_level_o starts from zero and increases by one every STEP_DIV clock edges. It saturates at full scale (all ones, 2^LVL_W-1).
- R4: drv_en_o is high only when all of these hold: both readiness flags are high, no fault is latched, oc_i is low and ss_level_o >= LOW_THR. After a clean start, drv_en_o rises after exactly LOW_THR*STEP_DIV edges.
- R5: oc_i high with no fault latched makes drv_en_o low in the same cycle. On the next edge the latch is set and ss_level_o becomes zero.
- R6: While the latch is set, drv_en_o stays low. ss_level_o keeps charging, and further overcurrent does not restart it.
- R7: On the edge where a latched fault sees full scale, ss_level_o becomes zero in every case. The latch clears if oc_i is low and stays set if oc_i is high, so a persistent overcurrent repeats full charge cycles with the drivers held off.
- R8: phase_lim_o equals min(phase_req_i, ss_level_o - LOW_THR) while drv_en_o is high and zero otherwise, so switching starts at zero phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| supply_ok_i | input | 1 | Supply above lockout level |
| ref_ok_i | input | 1 | Reference settled |
| oc_i | input | 1 | Overcurrent comparator output |
| phase_req_i | input | LVL_W | Requested phase command |
| drv_en_o | output | 1 | Gate driver enable |
| phase_lim_o | output | LVL_W | Clamped phase command |
| ss_level_o | output | LVL_W | Soft-start level |

## Verification
drv_en_o and phase_lim_o respond to oc_i and to the readiness flags in the same cycle. ss_level_o and the fault latch change on the clock edge that follows. The bench checks the same-cycle response straight after it changes an input, before any edge. All other checks are made at the falling edge after the rising edge under test, where a behavioural model advanced by that same edge supplies the expected values. The directed checks count edges from the event that starts them: LOW_THR*STEP_DIV edges until the drivers enable, and one full charge plus one edge for a hiccup release.

// File: rtl/hs_pkg.sv
package hs_pkg;
  typedef enum logic {
    LVL_RUN   = 1'b0,
    LVL_CLEAR = 1'b1
  } lvl_cmd_e;
endpackage

// File: rtl/hs_tick.sv
module hs_tick #(
  parameter int unsigned STEP_DIV = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  output logic tick_o
);
  localparam int unsigned CW = (STEP_DIV > 2) ? $clog2(STEP_DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(STEP_DIV - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (clr_i)          cnt_q <= '0;
    else if (cnt_q == LAST)  cnt_q <= '0;
    else                     cnt_q <= cnt_q + 1'b1;
  end

  assign tick_o = !clr_i && (cnt_q == LAST);

  // step spacing needs STEP_DIV >= 2
  p_tick_gap_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |=> !tick_o);
  p_clr_restart_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> !tick_o);
endmodule

// File: rtl/hs_level.sv
module hs_level #(
  parameter int unsigned LVL_W = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  hs_pkg::lvl_cmd_e cmd_i,
  input  logic             step_i,
  output logic [LVL_W-1:0] lvl_o,
  output logic             full_o
);
  import hs_pkg::*;

  logic [LVL_W-1:0] lvl_q;

  assign full_o = &lvl_q;
  assign lvl_o  = lvl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     lvl_q <= '0;
    else if (cmd_i == LVL_CLEAR)     lvl_q <= '0;
    else if (step_i && !full_o)      lvl_q <= lvl_q + 1'b1;
  end

  p_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_i == LVL_RUN && !step_i) |=> $stable(lvl_q));
  p_saturate_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full_o && cmd_i == LVL_RUN) |=> full_o);
  p_clear_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_i == LVL_CLEAR) |=> (lvl_q == '0));
endmodule

// File: rtl/hs_latch.sv
module hs_latch (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ready_i,
  input  logic             oc_i,
  input  logic             full_i,
  output hs_pkg::lvl_cmd_e cmd_o,
  output logic             fault_o
);
  import hs_pkg::*;

  logic fault_q, fault_d, clr;

  always_comb begin
    fault_d = fault_q;
    clr     = 1'b0;
    if (!ready_i) begin
      fault_d = 1'b0;
      clr     = 1'b1;
    end else if (!fault_q && oc_i) begin
      fault_d = 1'b1;
      clr     = 1'b1;
    end else if (fault_q && full_i) begin
      // release only after a full charge; retry if still faulted
      fault_d = oc_i;
      clr     = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) fault_q <= 1'b0;
    else         fault_q <= fault_d;
  end

  assign cmd_o   = clr ? LVL_CLEAR : LVL_RUN;
  assign fault_o = fault_q;

  p_set_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ready_i && !fault_q && oc_i) |=> fault_q);
  p_release_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(fault_q) |-> ($past(full_i) || !$past(ready_i)));
  p_retry_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ready_i && fault_q && full_i && oc_i) |=> fault_q);
  p_unready_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ready_i |=> !fault_q);
  p_charge_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ready_i && fault_q && !full_i) |-> cmd_o == LVL_RUN);
endmodule

// File: rtl/hiccup_seq.sv
module hiccup_seq #(
  parameter int unsigned LVL_W    = 6,
  parameter int unsigned STEP_DIV = 3,
  parameter int unsigned LOW_THR  = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             supply_ok_i,
  input  logic             ref_ok_i,
  input  logic             oc_i,
  input  logic [LVL_W-1:0] phase_req_i,
  output logic             drv_en_o,
  output logic [LVL_W-1:0] phase_lim_o,
  output logic [LVL_W-1:0] ss_level_o
);
  import hs_pkg::*;

  localparam logic [LVL_W-1:0] THR_V = LVL_W'(LOW_THR);

  logic             ready, fault, full, tick;
  lvl_cmd_e         cmd;
  logic [LVL_W-1:0] lvl, headroom;

  assign ready = supply_ok_i & ref_ok_i;

  hs_tick #(.STEP_DIV(STEP_DIV)) u_tick (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (cmd == LVL_CLEAR),
    .tick_o(tick)
  );

  hs_level #(.LVL_W(LVL_W)) u_level (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .cmd_i (cmd),
    .step_i(tick),
    .lvl_o (lvl),
    .full_o(full)
  );

  hs_latch u_latch (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .ready_i(ready),
    .oc_i   (oc_i),
    .full_i (full),
    .cmd_o  (cmd),
    .fault_o(fault)
  );

  assign drv_en_o    = ready & ~fault & ~oc_i & (lvl >= THR_V);
  assign headroom    = lvl - THR_V;
  assign phase_lim_o = !drv_en_o ? '0 :
                       (phase_req_i < headroom) ? phase_req_i : headroom;
  assign ss_level_o  = lvl;

  p_oc_kill_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    oc_i |-> !drv_en_o);
  p_unready_off_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ready |-> (!drv_en_o && phase_lim_o == '0));
  p_ref_wait_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ref_ok_i |=> (ss_level_o == '0));
  p_clamp_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    phase_lim_o <= phase_req_i);
  p_zero_start_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (drv_en_o && ss_level_o == THR_V) |-> phase_lim_o == '0);
  p_fault_quiet_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ready && !fault && oc_i) |=> !drv_en_o);
endmodule

// File: tb/tb_hiccup_seq.sv
module tb_hiccup_seq;
  localparam int W = 6, DIV = 3, THR = 4;
  localparam int FULL = (1 << W) - 1;
  localparam time T_CLK = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic sup = 1'b0, rdy = 1'b0, oc = 1'b0;
  logic [W-1:0] req = '0;
  logic drv_en_o;
  logic [W-1:0] phase_lim_o, ss_level_o;

  int n_chk = 0, n_bad = 0;
  int m_lvl = 0, m_cnt = 0;
  bit m_flt = 0;

  hiccup_seq #(.LVL_W(W), .STEP_DIV(DIV), .LOW_THR(THR)) dut (
    .clk_i(clk), .rst_ni(rst_n), .supply_ok_i(sup), .ref_ok_i(rdy),
    .oc_i(oc), .phase_req_i(req), .drv_en_o(drv_en_o),
    .phase_lim_o(phase_lim_o), .ss_level_o(ss_level_o));

  always #(T_CLK/2) clk = ~clk;

  function automatic int exp_drv();
    return (sup && rdy && !m_flt && !oc && m_lvl >= THR) ? 1 : 0;
  endfunction

  function automatic int exp_phase();
    int room;
    if (exp_drv() == 0) return 0;
    room = m_lvl - THR;
    return (int'(req) < room) ? int'(req) : room;
  endfunction

  task automatic check(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic compare();
    check("R3 level", int'(ss_level_o), m_lvl);
    check("R4 drive", int'(drv_en_o), exp_drv());
    check("R8 phase", int'(phase_lim_o), exp_phase());
  endtask

  task automatic model_edge();
    if (!(sup && rdy)) begin
      m_lvl = 0; m_cnt = 0; m_flt = 0;
    end else if (!m_flt && oc) begin
      m_flt = 1; m_lvl = 0; m_cnt = 0;
    end else if (m_flt && m_lvl == FULL) begin
      m_flt = oc; m_lvl = 0; m_cnt = 0;
    end else if (m_cnt == DIV - 1) begin
      m_cnt = 0;
      if (m_lvl < FULL) m_lvl++;
    end else begin
      m_cnt++;
    end
  endtask

  task automatic step();
    @(posedge clk);
    model_edge();
    @(negedge clk);
    #1;
    compare();
  endtask

  task automatic steps(int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic drive(logic s, logic r, logic o, logic [W-1:0] q);
    sup = s; rdy = r; oc = o; req = q;
    #1;
    compare();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    int hi, wraps, prev;
    @(negedge clk); #1;
    check("R1 reset level", int'(ss_level_o), 0);
    check("R1 reset drive", int'(drv_en_o), 0);
    check("R1 reset phase", int'(phase_lim_o), 0);
    @(negedge clk);
    rst_n = 1'b1;

    drive(0, 0, 0, W'(FULL));
    steps(5);
    check("R1 no supply level", int'(ss_level_o), 0);

    drive(1, 0, 0, W'(FULL));
    steps(20);
    check("R2 ref low level", int'(ss_level_o), 0);
    check("R2 ref low drive", int'(drv_en_o), 0);

    drive(1, 1, 0, W'(FULL));
    steps(THR * DIV - 1);
    check("R4 before threshold", int'(drv_en_o), 0);
    step();
    check("R4 at threshold", int'(drv_en_o), 1);
    check("R8 zero phase start", int'(phase_lim_o), 0);

    steps(FULL * DIV + 10);
    check("R3 saturated", int'(ss_level_o), FULL);
    check("R8 clamp to level", int'(phase_lim_o), FULL - THR);
    drive(1, 1, 0, W'(7));
    check("R8 clamp to request", int'(phase_lim_o), 7);

    drive(1, 1, 1, W'(FULL));
    check("R5 same-cycle off", int'(drv_en_o), 0);
    step();
    check("R5 level cleared", int'(ss_level_o), 0);
    hi = 0;
    for (int i = 0; i < FULL * DIV; i++) begin
      drive(1, 1, (i < 90) && (i % 30 == 7), W'(FULL));
      step();
      hi += int'(drv_en_o);
    end
    check("R6 drive held off", hi, 0);
    check("R6 charge not restarted", int'(ss_level_o), FULL);
    drive(1, 1, 0, W'(FULL));
    step();
    check("R7 release restarts level", int'(ss_level_o), 0);
    steps(THR * DIV);
    check("R7 drive after release", int'(drv_en_o), 1);

    drive(1, 1, 1, W'(FULL));
    hi = 0; wraps = 0; prev = int'(ss_level_o);
    for (int i = 0; i < 2 * (FULL * DIV + 1) + 5; i++) begin
      step();
      hi += int'(drv_en_o);
      if (prev == FULL && int'(ss_level_o) == 0) wraps++;
      prev = int'(ss_level_o);
    end
    check("R7 hiccup drive off", hi, 0);
    check("R7 hiccup retries", (wraps >= 2) ? 1 : 0, 1);
    drive(1, 1, 0, W'(FULL));
    steps(FULL * DIV + 1 + THR * DIV + 2);
    check("R7 recovery", int'(drv_en_o), 1);

    drive(1, 1, 1, W'(FULL));
    step();
    drive(1, 1, 0, W'(FULL));
    steps(10);
    drive(0, 1, 0, W'(FULL));
    check("R1 supply loss drive", int'(drv_en_o), 0);
    step();
    check("R1 supply loss level", int'(ss_level_o), 0);
    drive(1, 1, 0, W'(FULL));
    steps(THR * DIV);
    check("R1 latch reset by supply loss", int'(drv_en_o), 1);

    drive(1, 0, 0, W'(FULL));
    check("R2 ref loss drive", int'(drv_en_o), 0);
    step();
    check("R2 ref loss level", int'(ss_level_o), 0);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule